// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the context-switch engine for an 8-bit processor core. It sits between the core's instruction control and a byte-wide stack memory. An interrupt can be granted at an instruction boundary, or a software trap can be executed. In either case the sequencer writes the 16-bit program counter, the index register, the accumulator and the condition code register to a stack that grows downward. It then loads the program counter with the handler address and sets the interrupt mask bit in the condition codes. A return command reverses this. The bytes are read back in the opposite order, and all four registers are reloaded. Restoring the saved condition codes is what clears the mask bit again.

The core keeps the architectural registers. It presents their current values on the `*_in` ports and applies each `*_ld` strobe with the matching `*_out` value at the next clock edge. The stack pointer lives inside this block and is visible on `sp_out`. Stack reads are combinational: `stk_rdata` must reflect `stk_addr` in the same cycle.

The state machine has twelve states:
- `S_IDLE` waits for work.
- Entry runs `S_PSH_PCL`, `S_PSH_PCH`, `S_PSH_X`, `S_PSH_A`, `S_PSH_CC`, then `S_VEC`.
- Return runs `S_POP_CC`, `S_POP_A`, `S_POP_X`, `S_POP_PCH`, then `S_POP_PCL`.

The transitions are:
- `S_IDLE` to `S_PSH_PCL` on an accepted trap or maskable request.
- `S_IDLE` to `S_POP_CC` on a return command.
- Each state to the next state in its chain, unconditionally.
- `S_VEC` and `S_POP_PCL` back to `S_IDLE`.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, `busy` is 0, `sp_out` equals the parameter `SP_RST` (default 8'hFF), and neither `stk_we` nor `stk_re` is asserted.
- R2: A maskable request (`irq_req`) starts entry only when all three of these hold in the same cycle: the block is idle, `insn_done` is 1, and bit 3 (the mask bit, parameter `IBIT`) of `cc_in` is 0. Otherwise it has no effect: `busy` stays 0, and the stack pointer and registers keep their values.
- R3: Entry writes five bytes, one per cycle, each at the current stack pointer, and decrements the pointer after each write. The order is: PC bits 7:0, PC bits 15:8, X, A, CC. The pointer ends 5 below its start.
- R4: In the cycle after the last push, the block asserts `pc_ld` with the selected vector and `cc_ld` with the saved CC value with bit 3 forced to 1. All other bits of that value are unchanged.
- R5: `trap_cmd` starts entry whenever the block is idle, whatever the values of `cc_in` bit 3 and `insn_done`. The program counter is then loaded from `trap_vec` instead of `irq_vec`.
- R6: `ret_cmd` reads five bytes, one per cycle. Before each read it increments the stack pointer. The bytes restore, in order: CC, A, X, PC bits 15:8, PC bits 7:0. `pc_ld` comes in the last cycle, and the stack pointer ends 5 above its start.
- R7: `busy` is 1 for exactly 6 cycles on entry (the five pushes plus the vector load) and for exactly 5 cycles on return. It is 0 at all other times.
- R8: If several commands arrive in the same idle cycle, the trap wins over the return, and the return wins over a maskable request.
- R9: Trap, return and maskable requests that arrive while `busy` is 1 are ignored. They do not alter the running sequence and do not start a new one afterwards.
- R10: `stk_we` and `stk_re` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done | input | 1 | Instruction-boundary strobe |
| irq_req | input | 1 | Maskable interrupt request, already prioritised and held by the interrupt controller |
| irq_vec | input | 16 | Handler address for the maskable request |
| trap_cmd | input | 1 | Software trap command |
| trap_vec | input | 16 | Handler address for the trap |
| ret_cmd | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Current program counter |
| x_in | input | 8 | Current index register |
| a_in | input | 8 | Current accumulator |
| cc_in | input | 8 | Current condition codes |
| pc_ld | output | 1 | Load the program counter from `pc_out` |
| pc_out | output | 16 | New program counter value |
| x_ld | output | 1 | Load the index register from `x_out` |
| x_out | output | 8 | New index register value |
| a_ld | output | 1 | Load the accumulator from `a_out` |
| a_out | output | 8 | New accumulator value |
| cc_ld | output | 1 | Load the condition codes from `cc_out` |
| cc_out | output | 8 | New condition code value |
| stk_addr | output | 8 | Stack memory address |
| stk_we | output | 1 | Stack memory write strobe |
| stk_re | output | 1 | Stack memory read strobe |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data (combinational) |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Sequence in progress |

## Verification
Two arbitration cases are stressed on purpose.

The first is a trap and a maskable request raised in the same idle cycle. This is done both with the mask bit clear, when both would qualify, and with it set. The bench then checks that the handler address comes from `trap_vec`, and that only one five-byte frame was written.

The second is a return command raised together with a maskable request, where the restored context would re-enable the request. The bench checks that the pop sequence runs, and that no push begins until the request is raised again after `busy` falls.

Random register contents, vectors and mask states between these cases exercise every byte lane of the frame.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PSH_PCL,
        S_PSH_PCH,
        S_PSH_X,
        S_PSH_A,
        S_PSH_CC,
        S_VEC,
        S_POP_CC,
        S_POP_A,
        S_POP_X,
        S_POP_PCH,
        S_POP_PCL
    } seq_state_t;

    typedef enum logic [1:0] {
        GO_NONE,
        GO_TRAP,
        GO_RET,
        GO_IRQ
    } seq_go_t;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb #(
    parameter int DW   = 8,
    parameter int IBIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          insn_done,
    input  logic          irq_req,
    input  logic          trap_cmd,
    input  logic          ret_cmd,
    input  logic [DW-1:0] cc_in,
    output irq_seq_pkg::seq_go_t go
);
    import irq_seq_pkg::*;

    logic irq_ok;

    assign irq_ok = irq_req && insn_done && !cc_in[IBIT];

    always_comb begin
        go = GO_NONE;
        if (idle) begin
            if (trap_cmd) begin
                go = GO_TRAP;
            end else if (ret_cmd) begin
                go = GO_RET;
            end else if (irq_ok) begin
                go = GO_IRQ;
            end
        end
    end

    // R2
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cc_in[IBIT] && !trap_cmd && !ret_cmd) |-> (go == GO_NONE));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (go == GO_NONE));

endmodule

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
    parameter int            SPW    = 8,
    parameter logic [SPW-1:0] SP_RST = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    output logic [SPW-1:0] sp,
    output logic [SPW-1:0] addr
);
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] sp_inc;

    assign sp_inc = sp_q + 1'b1;
    assign sp     = sp_q;
    assign addr   = pop ? sp_inc : sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_RST;
        end else if (push) begin
            sp_q <= sp_q - 1'b1;
        end else if (pop) begin
            sp_q <= sp_inc;
        end
    end

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

    // R3
    post_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sp == $past(sp) - 1'b1));

    // R6
    pre_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (sp == $past(addr)));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm #(
    parameter int DW   = 8,
    parameter int IBIT = 3,
    localparam int PCW = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  irq_seq_pkg::seq_go_t go,
    input  logic [PCW-1:0] irq_vec,
    input  logic [PCW-1:0] trap_vec,
    input  logic [PCW-1:0] pc_in,
    input  logic [DW-1:0]  x_in,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  cc_in,
    input  logic [DW-1:0]  rdata,
    output logic           idle,
    output logic           push,
    output logic           pop,
    output logic [DW-1:0]  wdata,
    output logic           pc_ld,
    output logic [PCW-1:0] pc_out,
    output logic           x_ld,
    output logic [DW-1:0]  x_out,
    output logic           a_ld,
    output logic [DW-1:0]  a_out,
    output logic           cc_ld,
    output logic [DW-1:0]  cc_out
);
    import irq_seq_pkg::*;

    seq_state_t     state, nxt;
    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] vec_q;
    logic [DW-1:0]  x_q;
    logic [DW-1:0]  a_q;
    logic [DW-1:0]  cc_q;
    logic [DW-1:0]  pch_q;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (go == GO_TRAP || go == GO_IRQ) begin
                    nxt = S_PSH_PCL;
                end else if (go == GO_RET) begin
                    nxt = S_POP_CC;
                end
            end
            S_PSH_PCL: nxt = S_PSH_PCH;
            S_PSH_PCH: nxt = S_PSH_X;
            S_PSH_X:   nxt = S_PSH_A;
            S_PSH_A:   nxt = S_PSH_CC;
            S_PSH_CC:  nxt = S_VEC;
            S_VEC:     nxt = S_IDLE;
            S_POP_CC:  nxt = S_POP_A;
            S_POP_A:   nxt = S_POP_X;
            S_POP_X:   nxt = S_POP_PCH;
            S_POP_PCH: nxt = S_POP_PCL;
            S_POP_PCL: nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            vec_q <= '0;
            x_q   <= '0;
            a_q   <= '0;
            cc_q  <= '0;
            pch_q <= '0;
        end else begin
            if (state == S_IDLE && (go == GO_TRAP || go == GO_IRQ)) begin
                pc_q  <= pc_in;
                x_q   <= x_in;
                a_q   <= a_in;
                cc_q  <= cc_in;
                vec_q <= (go == GO_TRAP) ? trap_vec : irq_vec;
            end
            if (state == S_POP_PCH) begin
                pch_q <= rdata;
            end
        end
    end

    always_comb begin
        idle   = 1'b0;
        push   = 1'b0;
        pop    = 1'b0;
        wdata  = '0;
        pc_ld  = 1'b0;
        pc_out = '0;
        x_ld   = 1'b0;
        x_out  = '0;
        a_ld   = 1'b0;
        a_out  = '0;
        cc_ld  = 1'b0;
        cc_out = '0;
        unique case (state)
            S_IDLE: idle = 1'b1;
            S_PSH_PCL: begin
                push  = 1'b1;
                wdata = pc_q[DW-1:0];
            end
            S_PSH_PCH: begin
                push  = 1'b1;
                wdata = pc_q[PCW-1:DW];
            end
            S_PSH_X: begin
                push  = 1'b1;
                wdata = x_q;
            end
            S_PSH_A: begin
                push  = 1'b1;
                wdata = a_q;
            end
            S_PSH_CC: begin
                push  = 1'b1;
                wdata = cc_q;
            end
            S_VEC: begin
                pc_ld  = 1'b1;
                pc_out = vec_q;
                cc_ld  = 1'b1;
                cc_out = cc_q | (DW'(1) << IBIT);
            end
            S_POP_CC: begin
                pop    = 1'b1;
                cc_ld  = 1'b1;
                cc_out = rdata;
            end
            S_POP_A: begin
                pop   = 1'b1;
                a_ld  = 1'b1;
                a_out = rdata;
            end
            S_POP_X: begin
                pop   = 1'b1;
                x_ld  = 1'b1;
                x_out = rdata;
            end
            S_POP_PCH: pop = 1'b1;
            S_POP_PCL: begin
                pop    = 1'b1;
                pc_ld  = 1'b1;
                pc_out = {pch_q, rdata};
            end
            default: idle = 1'b0;
        endcase
    end

    // R5
    trap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && go == GO_TRAP) |=> push);

    // R4
    vec_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_ld && pc_ld && !pop) |-> cc_out[IBIT]);

    // R4
    vec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && !pop) |-> $past(push));

endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top #(
    parameter int            DW     = 8,
    parameter int            SPW    = 8,
    parameter int            IBIT   = 3,
    parameter logic [SPW-1:0] SP_RST = '1,
    localparam int           PCW    = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           insn_done,
    input  logic           irq_req,
    input  logic [PCW-1:0] irq_vec,
    input  logic           trap_cmd,
    input  logic [PCW-1:0] trap_vec,
    input  logic           ret_cmd,
    input  logic [PCW-1:0] pc_in,
    input  logic [DW-1:0]  x_in,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  cc_in,
    output logic           pc_ld,
    output logic [PCW-1:0] pc_out,
    output logic           x_ld,
    output logic [DW-1:0]  x_out,
    output logic           a_ld,
    output logic [DW-1:0]  a_out,
    output logic           cc_ld,
    output logic [DW-1:0]  cc_out,
    output logic [SPW-1:0] stk_addr,
    output logic           stk_we,
    output logic           stk_re,
    output logic [DW-1:0]  stk_wdata,
    input  logic [DW-1:0]  stk_rdata,
    output logic [SPW-1:0] sp_out,
    output logic           busy
);
    import irq_seq_pkg::*;

    seq_go_t go;
    logic    idle;
    logic    push;
    logic    pop;

    irq_seq_arb #(.DW(DW), .IBIT(IBIT)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .trap_cmd  (trap_cmd),
        .ret_cmd   (ret_cmd),
        .cc_in     (cc_in),
        .go        (go)
    );

    irq_seq_fsm #(.DW(DW), .IBIT(IBIT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .irq_vec  (irq_vec),
        .trap_vec (trap_vec),
        .pc_in    (pc_in),
        .x_in     (x_in),
        .a_in     (a_in),
        .cc_in    (cc_in),
        .rdata    (stk_rdata),
        .idle     (idle),
        .push     (push),
        .pop      (pop),
        .wdata    (stk_wdata),
        .pc_ld    (pc_ld),
        .pc_out   (pc_out),
        .x_ld     (x_ld),
        .x_out    (x_out),
        .a_ld     (a_ld),
        .a_out    (a_out),
        .cc_ld    (cc_ld),
        .cc_out   (cc_out)
    );

    irq_seq_sp #(.SPW(SPW), .SP_RST(SP_RST)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .sp    (sp_out),
        .addr  (stk_addr)
    );

    assign stk_we = push;
    assign stk_re = pop;
    assign busy   = !idle;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && sp_out == SP_RST));

    // R7
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we || stk_re || pc_ld) |-> busy);

endmodule

// File: tb/sim_irq_seq_top.sv
module sim_irq_seq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] irq_vec = '0;
    logic        trap_cmd = 1'b0;
    logic [15:0] trap_vec = '0;
    logic        ret_cmd = 1'b0;
    logic        pc_ld, x_ld, a_ld, cc_ld;
    logic [15:0] pc_out;
    logic [7:0]  x_out, a_out, cc_out;
    logic [7:0]  stk_addr, stk_wdata, stk_rdata, sp_out;
    logic        stk_we, stk_re, busy;

    logic [15:0] pc_r;
    logic [7:0]  x_r, a_r, cc_r;
    logic [7:0]  mem [256];

    int n_chk = 0;
    int n_fail = 0;
    int busy_cnt;
    int we_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
        .irq_vec(irq_vec), .trap_cmd(trap_cmd), .trap_vec(trap_vec),
        .ret_cmd(ret_cmd), .pc_in(pc_r), .x_in(x_r), .a_in(a_r), .cc_in(cc_r),
        .pc_ld(pc_ld), .pc_out(pc_out), .x_ld(x_ld), .x_out(x_out),
        .a_ld(a_ld), .a_out(a_out), .cc_ld(cc_ld), .cc_out(cc_out),
        .stk_addr(stk_addr), .stk_we(stk_we), .stk_re(stk_re),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .sp_out(sp_out),
        .busy(busy)
    );

    // Core register file and stack memory of the surrounding system
    assign stk_rdata = mem[stk_addr];

    always @(posedge clk) begin
        if (stk_we) mem[stk_addr] <= stk_wdata;
        if (pc_ld) pc_r <= pc_out;
        if (x_ld) x_r <= x_out;
        if (a_ld) a_r <= a_out;
        if (cc_ld) cc_r <= cc_out;
    end

    always @(negedge clk) begin
        if (stk_we && stk_re) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10: we=%0d re=%0d expected not both", stk_we, stk_re);
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] set_mask(input logic [7:0] c);
        return c | 8'h08;
    endfunction

    // Drive one cycle of commands, then wait until idle; counts busy cycles and writes
    task automatic issue(input bit t, input bit r, input bit q, input bit d);
        @(negedge clk);
        trap_cmd = t; ret_cmd = r; irq_req = q; insn_done = d;
        @(negedge clk);
        trap_cmd = 0; ret_cmd = 0; irq_req = 0; insn_done = 0;
        busy_cnt = 0;
        we_cnt = 0;
        while (busy) begin
            busy_cnt++;
            if (stk_we) we_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic load_ctx(input logic [15:0] p, input logic [7:0] x,
                            input logic [7:0] a, input logic [7:0] c);
        @(negedge clk);
        force_regs(p, x, a, c);
    endtask

    task automatic force_regs(input logic [15:0] p, input logic [7:0] x,
                              input logic [7:0] a, input logic [7:0] c);
        pc_r = p; x_r = x; a_r = a; cc_r = c;
    endtask

    // Entry with expected-frame checks; use_trap selects the trap path
    task automatic entry_chk(input bit use_trap, input bit also_irq, input string tag);
        logic [15:0] p0, v;
        logic [7:0]  x0, a0, c0, s0;
        p0 = pc_r; x0 = x_r; a0 = a_r; c0 = cc_r; s0 = sp_out;
        v = use_trap ? trap_vec : irq_vec;
        issue(use_trap, 1'b0, use_trap ? also_irq : 1'b1, 1'b1);
        check(mem[s0] == p0[7:0] && mem[8'(s0-1)] == p0[15:8] &&
              mem[8'(s0-2)] == x0 && mem[8'(s0-3)] == a0 &&
              mem[8'(s0-4)] == c0, {tag, " R3 frame"},
              {mem[s0], mem[8'(s0-1)], mem[8'(s0-2)], mem[8'(s0-3)]},
              {p0[7:0], p0[15:8], x0, a0});
        check(sp_out == 8'(s0 - 5), {tag, " R3 sp"}, sp_out, 8'(s0 - 5));
        check(pc_r == v, {tag, " R4/R5 vector"}, pc_r, v);
        check(cc_r == set_mask(c0), {tag, " R4 mask"}, cc_r, set_mask(c0));
        check(busy_cnt == 6 && we_cnt == 5, {tag, " R7 entry busy"},
              {busy_cnt[15:0], we_cnt[15:0]}, {16'd6, 16'd5});
    endtask

    task automatic return_chk(input bit also_irq, input string tag);
        logic [15:0] p0;
        logic [7:0]  x0, a0, c0, s0;
        s0 = sp_out;
        c0 = mem[8'(s0+1)]; a0 = mem[8'(s0+2)]; x0 = mem[8'(s0+3)];
        p0 = {mem[8'(s0+4)], mem[8'(s0+5)]};
        issue(1'b0, 1'b1, also_irq, also_irq);
        check(pc_r == p0 && x_r == x0 && a_r == a0 && cc_r == c0,
              {tag, " R6 restore"}, {pc_r, x_r, a_r}, {p0, x0, a0});
        check(sp_out == 8'(s0 + 5), {tag, " R6 sp"}, sp_out, 8'(s0 + 5));
        check(busy_cnt == 5 && we_cnt == 0, {tag, " R7 return busy"},
              {busy_cnt[15:0], we_cnt[15:0]}, {16'd5, 16'd0});
    endtask

    task automatic ignored_chk(input bit q, input bit d, input string tag);
        logic [15:0] p0;
        logic [7:0]  s0;
        p0 = pc_r; s0 = sp_out;
        issue(1'b0, 1'b0, q, d);
        check(busy_cnt == 0 && sp_out == s0 && pc_r == p0, {tag, " R2 ignored"},
              {busy_cnt[7:0], sp_out}, {8'd0, s0});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7263));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        force_regs(16'h1234, 8'h11, 8'h22, 8'h00);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && sp_out == 8'hFF && !stk_we && !stk_re, "R1 reset",
              {busy, sp_out}, {1'b0, 8'hFF});
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && sp_out == 8'hFF, "R1 after release", sp_out, 8'hFF);

        // R2 request without boundary strobe ignored; with mask set ignored
        irq_vec = 16'hC000; trap_vec = 16'hE000;
        ignored_chk(1'b1, 1'b0, "no-boundary");
        load_ctx(16'h1234, 8'h11, 8'h22, 8'h08);
        ignored_chk(1'b1, 1'b1, "masked");

        // R2/R3/R4 basic maskable entry and R6 return
        load_ctx(16'hA55A, 8'h3C, 8'hC3, 8'hF1);
        entry_chk(1'b0, 1'b0, "irq");
        // R2 after entry mask is set; further request ignored
        ignored_chk(1'b1, 1'b1, "nested-masked");
        // R5 trap nests despite mask
        trap_vec = 16'hE123;
        entry_chk(1'b1, 1'b0, "trap-nested");
        return_chk(1'b0, "trap-ret");
        check(cc_r[3] == 1'b1, "R6 inner cc keeps mask", cc_r, 8'hF9);
        return_chk(1'b0, "irq-ret");
        check(cc_r[3] == 1'b0, "R6 mask cleared", cc_r, 8'hF1);

        // R8 trap beats maskable in the same cycle (mask clear)
        load_ctx(16'h0F0F, 8'h01, 8'h02, 8'h00);
        irq_vec = 16'hC0DE; trap_vec = 16'hBEEF;
        entry_chk(1'b1, 1'b1, "R8 trap-vs-irq");
        // R8 return beats maskable in the same cycle; R9 no push afterwards
        return_chk(1'b1, "R8 ret-vs-irq");
        @(negedge clk);
        check(busy == 0 && sp_out == 8'hFF, "R8 no entry after ret", sp_out, 8'hFF);
        // R8 trap beats return
        issue(1'b1, 1'b1, 1'b0, 1'b0);
        check(sp_out == 8'hFA && pc_r == 16'hBEEF, "R8 trap-vs-ret",
              {sp_out, pc_r}, {8'hFA, 16'hBEEF});
        return_chk(1'b0, "R8 cleanup");

        // R9 commands during busy are ignored
        @(negedge clk);
        irq_req = 1; insn_done = 1;
        @(negedge clk);
        irq_req = 0; insn_done = 0;
        trap_cmd = 1; ret_cmd = 1;
        @(negedge clk);
        @(negedge clk);
        trap_cmd = 0; ret_cmd = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(busy == 0 && sp_out == 8'hFA, "R9 busy ignores", sp_out, 8'hFA);
        return_chk(1'b0, "R9 cleanup");

        // Random mix
        for (int k = 0; k < 60; k++) begin
            logic [7:0] c;
            c = 8'($urandom);
            load_ctx(16'($urandom), 8'($urandom), 8'($urandom), c);
            irq_vec = 16'($urandom); trap_vec = 16'($urandom);
            if ($urandom % 2 == 0) begin
                entry_chk(1'b1, 1'($urandom), "rnd-trap R5");
                return_chk(1'b0, "rnd-trap");
            end else if (c[3]) begin
                ignored_chk(1'b1, 1'b1, "rnd-masked");
            end else begin
                entry_chk(1'b0, 1'b0, "rnd-irq R2");
                return_chk(1'b0, "rnd-irq");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule